// File: doc/BRIEF.md
# Parallel-Dot-Product Square Matrix Multiplier

The block computes C = A × B for two square integer matrices whose size is chosen at run time, up to a compile-time maximum (default 64). A `start` strobe latches the run-time size. The block then works through three phases in turn. In the load phase it accepts dim×dim beats in row-major order from a valid/ready stream. Each beat carries one element of both operands. The first operand arrives as a complex word, and only its real half is kept. In the compute phase it produces one result element per clock. In the drain phase it streams the result matrix out, also in row-major order, on a second valid/ready stream. A one-cycle `done` strobe closes each run.

The first operand's storage is split by column and the second operand's by row. A whole row of A and a whole column of B are therefore available in a single cycle. A fixed-width array of MAX_DIM multipliers, followed by a registered adder tree, evaluates a full-length dot product for every element. Terms whose index is at or beyond the run-time size are forced to zero. The fixed-length sum then equals the true one, whatever the storage held from earlier runs.

Top module: `matmul_par`

## Requirements
- R1: While reset is held and after it is released, `in_ready`, `out_valid` and `done` are all low until a valid run is started.
- R2: The first operand is taken from the low DATA_W bits (real part) of `in_a`. The upper DATA_W bits (imaginary part) have no effect on any result.
- R3: After a valid start, exactly dim×dim input beats are accepted in row-major order. The column index returns to 0 after dim columns and the row then advances. `in_ready` falls after the last of these beats.
- R4: Each result C[i][j] equals the sum over k < dim of A[i][k]·B[k][j], computed in 32-bit two's-complement arithmetic that wraps on overflow. This holds for dim = 1, 7 and 64.
- R5: Matrix entries left in storage from an earlier, larger run at row or column index ≥ dim have no effect on results.
- R6: Results are emitted in row-major order, exactly dim×dim beats. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is held.
- R7: `done` is high for exactly one cycle: the cycle after the final output beat is accepted.
- R8: A `start` pulse that arrives while a run is in progress is ignored, and the run in progress completes with its original size.
- R9: A start with dim = 0 or dim > MAX_DIM raises `done` in the next cycle. It accepts no input beats and produces no output beats.
- R10: `in_ready` is high only in the load phase and `out_valid` only in the drain phase. The two are never high together.
- R11: The first output beat becomes valid no earlier than dim×dim cycles and no later than dim×dim + log2(MAX_DIM) + 2 cycles after the clock edge that accepts the final input beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only when idle |
| dim | input | $clog2(MAX_DIM+1) | Run-time matrix size, latched at start |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts an input beat |
| in_a | input | 2×DATA_W | First operand: {imaginary, real} |
| in_b | input | DATA_W | Second operand, signed integer |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer accepts a result beat |
| out_data | output | DATA_W | Result element, signed integer |
| done | output | 1 | One-cycle end-of-run strobe |

## Verification
The hardest condition to reach from the ports is masking: full-length dot products only prove correct when the storage beyond the active size holds nonzero leftovers. The stimulus therefore first runs a full 64×64 product with random data and then a 7×7 run without any reset in between. Every out-of-range entry still holds large random values at that point, so a missing or off-by-one mask corrupts the scoreboard results. Random backpressure on the output and a start pulse injected during the load phase exercise the stall-hold and busy-ignore paths.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD,
        PH_CALC,
        PH_DRAIN,
        PH_DONE
    } mm_phase_e;

endpackage

// File: rtl/mm_dot_tree.sv
module mm_dot_tree #(
    parameter int N  = 64,
    parameter int W  = 32,
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [TW-1:0] in_tag,
    input  logic [W-1:0]  a_vec [N],
    input  logic [W-1:0]  b_vec [N],
    output logic          out_valid,
    output logic [TW-1:0] out_tag,
    output logic [W-1:0]  out_sum
);
    localparam int LG  = (N > 1) ? $clog2(N) : 1;
    localparam int NP  = 1 << LG;
    localparam int LAT = LG + 1;

    typedef struct packed {
        logic [LAT-1:0]         vld;
        logic [LAT-1:0][TW-1:0] tag;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [W-1:0] prod    [NP];
    logic [W-1:0] node_q  [2*NP-1];

    // lane products; padding lanes contribute zero
    for (genvar m = 0; m < NP; m++) begin : g_lane
        if (m < N) begin : g_real
            assign prod[m] = a_vec[m] * b_vec[m];
        end else begin : g_pad
            assign prod[m] = '0;
        end
    end

    // heap-ordered tree: node n sums children 2n+1 and 2n+2, every node registered
    always_ff @(posedge clk) begin
        for (int m = 0; m < NP; m++) begin
            node_q[NP-1+m] <= prod[m];
        end
        for (int n = 0; n < NP-1; n++) begin
            node_q[n] <= node_q[2*n+1] + node_q[2*n+2];
        end
    end

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.vld = {pipe_q.vld[LAT-2:0], in_valid};
        pipe_d.tag = {pipe_q.tag[LAT-2:0], in_tag};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q.vld <= '0;
            pipe_q.tag <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.vld[LAT-1];
    assign out_tag   = pipe_q.tag[LAT-1];
    assign out_sum   = node_q[0];

    // R4
    tree_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pipe_q.vld[LAT-2]) |-> out_valid);

endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
    import mm_pkg::*;
#(
    parameter int MAX_DIM = 64
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic [$clog2(MAX_DIM+1)-1:0]       dim_in,
    input  logic                               in_valid,
    input  logic                               out_ready,
    input  logic                               res_valid,
    output logic                               in_ready,
    output logic                               load_we,
    output logic [$clog2(MAX_DIM)-1:0]         load_row,
    output logic [$clog2(MAX_DIM)-1:0]         load_col,
    output logic                               iss_valid,
    output logic [$clog2(MAX_DIM)-1:0]         iss_row,
    output logic [$clog2(MAX_DIM)-1:0]         iss_col,
    output logic [$clog2(MAX_DIM*MAX_DIM)-1:0] iss_tag,
    output logic [$clog2(MAX_DIM*MAX_DIM)-1:0] rd_idx,
    output logic [$clog2(MAX_DIM+1)-1:0]       dim_q,
    output logic                               out_valid,
    output logic                               done
);
    localparam int IW = $clog2(MAX_DIM+1);
    localparam int AW = $clog2(MAX_DIM);
    localparam int CW = $clog2(MAX_DIM*MAX_DIM+1);
    localparam int OW = $clog2(MAX_DIM*MAX_DIM);

    typedef struct packed {
        mm_phase_e     phase;
        logic [IW-1:0] dim;
        logic [AW-1:0] row;
        logic [AW-1:0] col;
        logic [CW-1:0] cnt;
        logic [AW-1:0] ci;
        logic [AW-1:0] cj;
        logic [CW-1:0] iss;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic [CW-1:0] total;
    logic          bad_dim;

    assign total   = CW'(s_q.dim) * CW'(s_q.dim);
    assign bad_dim = (dim_in == '0) || (dim_in > IW'(MAX_DIM));

    always_comb begin
        s_d = s_q;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    if (bad_dim) begin
                        s_d.phase = PH_DONE;
                    end else begin
                        s_d.phase = PH_LOAD;
                        s_d.dim   = dim_in;
                        s_d.row   = '0;
                        s_d.col   = '0;
                        s_d.cnt   = '0;
                    end
                end
            end
            PH_LOAD: begin
                if (in_valid) begin
                    if (IW'(s_q.col) == s_q.dim - 1'b1) begin
                        s_d.col = '0;
                        s_d.row = s_q.row + 1'b1;
                    end else begin
                        s_d.col = s_q.col + 1'b1;
                    end
                    if (s_q.cnt == total - 1'b1) begin
                        s_d.phase = PH_CALC;
                        s_d.cnt   = '0;
                        s_d.ci    = '0;
                        s_d.cj    = '0;
                        s_d.iss   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            PH_CALC: begin
                if (s_q.iss != total) begin
                    s_d.iss = s_q.iss + 1'b1;
                    if (IW'(s_q.cj) == s_q.dim - 1'b1) begin
                        s_d.cj = '0;
                        s_d.ci = s_q.ci + 1'b1;
                    end else begin
                        s_d.cj = s_q.cj + 1'b1;
                    end
                end
                if (res_valid) begin
                    if (s_q.cnt == total - 1'b1) begin
                        s_d.phase = PH_DRAIN;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            PH_DRAIN: begin
                if (out_ready) begin
                    if (s_q.cnt == total - 1'b1) begin
                        s_d.phase = PH_DONE;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            PH_DONE: s_d.phase = PH_IDLE;
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready  = (s_q.phase == PH_LOAD);
    assign load_we   = in_ready && in_valid;
    assign load_row  = s_q.row;
    assign load_col  = s_q.col;
    assign iss_valid = (s_q.phase == PH_CALC) && (s_q.iss != total);
    assign iss_row   = s_q.ci;
    assign iss_col   = s_q.cj;
    assign iss_tag   = s_q.iss[OW-1:0];
    assign rd_idx    = s_q.cnt[OW-1:0];
    assign dim_q     = s_q.dim;
    assign out_valid = (s_q.phase == PH_DRAIN);
    assign done      = (s_q.phase == PH_DONE);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    bad_dim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_IDLE && start && bad_dim) |=> (done && !in_ready));

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE && start) |=> $stable(dim_q));

    // R10
    rdy_vld_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R6
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(rd_idx)));

    // R3
    col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_we && IW'(load_col) == dim_q - 1'b1) |=> (load_col == '0));

endmodule

// File: rtl/matmul_par.sv
module matmul_par #(
    parameter int MAX_DIM = 64,
    parameter int DATA_W  = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [$clog2(MAX_DIM+1)-1:0] dim,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [2*DATA_W-1:0]          in_a,
    input  logic [DATA_W-1:0]            in_b,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [DATA_W-1:0]            out_data,
    output logic                         done
);
    localparam int IW = $clog2(MAX_DIM+1);
    localparam int AW = $clog2(MAX_DIM);
    localparam int OW = $clog2(MAX_DIM*MAX_DIM);

    logic          load_we, iss_valid, res_valid;
    logic [AW-1:0] load_row, load_col, iss_row, iss_col;
    logic [OW-1:0] iss_tag, rd_idx, res_tag;
    logic [IW-1:0] dim_q;
    logic [DATA_W-1:0] res_sum;
    logic          unused_imag;

    // A is split by column (a_mem[row][col], one bank per col),
    // B by row (b_mem[row][col], one bank per row)
    logic [DATA_W-1:0] a_mem [MAX_DIM][MAX_DIM];
    logic [DATA_W-1:0] b_mem [MAX_DIM][MAX_DIM];
    logic [DATA_W-1:0] c_mem [MAX_DIM*MAX_DIM];

    logic [DATA_W-1:0] row_v [MAX_DIM];
    logic [DATA_W-1:0] col_v [MAX_DIM];

    assign unused_imag = ^in_a[2*DATA_W-1:DATA_W];

    mm_ctrl #(.MAX_DIM(MAX_DIM)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dim_in    (dim),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .res_valid (res_valid),
        .in_ready  (in_ready),
        .load_we   (load_we),
        .load_row  (load_row),
        .load_col  (load_col),
        .iss_valid (iss_valid),
        .iss_row   (iss_row),
        .iss_col   (iss_col),
        .iss_tag   (iss_tag),
        .rd_idx    (rd_idx),
        .dim_q     (dim_q),
        .out_valid (out_valid),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (load_we) begin
            a_mem[load_row][load_col] <= in_a[DATA_W-1:0];
            b_mem[load_row][load_col] <= in_b;
        end
        if (res_valid) begin
            c_mem[res_tag] <= res_sum;
        end
    end

    // whole row of A and whole column of B, lanes at or beyond dim forced to zero
    for (genvar k = 0; k < MAX_DIM; k++) begin : g_mask
        assign row_v[k] = (IW'(k) < dim_q) ? a_mem[iss_row][k] : '0;
        assign col_v[k] = (IW'(k) < dim_q) ? b_mem[k][iss_col] : '0;
    end

    mm_dot_tree #(.N(MAX_DIM), .W(DATA_W), .TW(OW)) u_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (iss_valid),
        .in_tag    (iss_tag),
        .a_vec     (row_v),
        .b_vec     (col_v),
        .out_valid (res_valid),
        .out_tag   (res_tag),
        .out_sum   (res_sum)
    );

    assign out_data = c_mem[rd_idx];

    // R6
    drain_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_data));

    // R10
    res_only_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (!in_ready && !out_valid));

endmodule

// File: tb/matmul_par_tb.sv
module matmul_par_tb;
    localparam int MAXD = 64;
    localparam int DW   = 32;
    localparam int IW   = $clog2(MAXD+1);
    localparam int LGM  = $clog2(MAXD);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [IW-1:0] dim = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [2*DW-1:0] in_a = '0;
    logic [DW-1:0] in_b = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [DW-1:0] out_data;
    logic          done;

    matmul_par #(.MAX_DIM(MAXD), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dim(dim),
        .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .done(done)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int exp_q[$];
    int ma[MAXD][MAXD];
    int mb[MAXD][MAXD];
    bit rand_ready = 1'b0;
    bit saw_first = 1'b0;
    int first_ov = 0;
    int last_acc = 0;
    int n_out = 0;
    bit excl_bad = 1'b0;
    bit prev_stall = 1'b0;
    logic [DW-1:0] prev_data = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    always @(posedge clk) begin
        #2;
        out_ready = rand_ready ? 1'($urandom % 2) : 1'b1;
    end

    // monitor: pop expected results as the design emits them
    always @(negedge clk) begin
        if (rst_n) begin
            if (in_ready && out_valid) excl_bad = 1'b1;
            if (prev_stall)
                check(out_valid && out_data == prev_data, "R6", "held data",
                      longint'(out_data), longint'(prev_data));
            if (out_valid && !saw_first) begin
                saw_first = 1'b1;
                first_ov  = cyc;
            end
            if (out_valid && out_ready) begin
                n_out++;
                last_acc = cyc;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "extra output beat", n_out, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    // R4 R5 R2 values, R6 order
                    check(out_data == DW'(e), "R4", "result element",
                          longint'(signed'(out_data)), longint'(e));
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    task automatic run_mm(input int d, input bit rr, input bit inject);
        int load_end;
        int guard;
        rand_ready = rr;
        saw_first  = 1'b0;
        n_out      = 0;
        for (int r = 0; r < d; r++)
            for (int c = 0; c < d; c++) begin
                ma[r][c] = int'($urandom);
                mb[r][c] = int'($urandom);
            end
        for (int i = 0; i < d; i++)
            for (int j = 0; j < d; j++) begin
                int s;
                s = 0;
                for (int k = 0; k < d; k++) s += ma[i][k] * mb[k][j];
                exp_q.push_back(s);
            end
        @(negedge clk);
        start = 1'b1;
        dim   = IW'(d);
        @(negedge clk);
        start = 1'b0;
        for (int r = 0; r < d; r++)
            for (int c = 0; c < d; c++) begin
                in_valid = 1'b1;
                in_a = {$urandom, ma[r][c]};
                in_b = mb[r][c];
                if (inject && r == 0 && c == 2) begin
                    start = 1'b1;   // R8: ignored, size stays d
                    dim   = IW'(3);
                end
                while (!in_ready) @(negedge clk);
                @(negedge clk);
                start = 1'b0;
            end
        in_valid = 1'b0;
        load_end = cyc;
        check(!in_ready, "R3", "in_ready after last beat", in_ready, 0);
        guard = 0;
        while (!done && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
        check(done, "R7", "done seen", done, 1);
        check(cyc == last_acc + 1, "R7", "done cycle after last beat", cyc, last_acc + 1);
        check(n_out == d * d, "R6", "output beat count", n_out, d * d);
        check(exp_q.size() == 0, "R4", "results outstanding", exp_q.size(), 0);
        check(first_ov - load_end >= d * d && first_ov - load_end <= d * d + LGM + 2,
              "R11", "drain start latency", first_ov - load_end, d * d + LGM + 1);
        @(negedge clk);
        check(!done, "R7", "done one cycle", done, 0);
        rand_ready = 1'b0;
    endtask

    task automatic run_bad(input int d);
        n_out = 0;
        @(negedge clk);
        start = 1'b1;
        dim   = IW'(d);
        @(negedge clk);
        start = 1'b0;
        check(done && !in_ready, "R9", "immediate done", done, 1);
        @(negedge clk);
        check(!done && !in_ready && !out_valid, "R9", "returns idle", done, 0);
        repeat (3) @(negedge clk);
        check(n_out == 0 && !in_ready, "R9", "no beats", n_out, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(!in_ready && !out_valid && !done, "R1", "outputs in reset",
              {in_ready, out_valid, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!in_ready && !out_valid && !done, "R1", "outputs after reset",
              {in_ready, out_valid, done}, 0);

        run_mm(7, 1'b0, 1'b0);     // R2 R3 R4 base case
        run_mm(64, 1'b1, 1'b0);    // R4 full size, R6 backpressure
        run_mm(7, 1'b1, 1'b0);     // R5 leftovers from the 64 run
        run_mm(1, 1'b0, 1'b0);     // R4 single element
        run_mm(7, 1'b0, 1'b1);     // R8 start during load
        run_bad(0);                // R9
        run_bad(100);              // R9
        run_mm(2, 1'b1, 1'b0);

        check(!excl_bad, "R10", "ready/valid exclusive", excl_bad, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule